// File: doc/BRIEF.md
# PCI Slot Hotplug Event Controller

This block keeps three 32-bit slot bitmaps for a PCI bus segment: which slots hold a device, which slots may be hot-removed, and which slots have a removal waiting for the guest. Platform hotplug logic reports insertion, removal and boot-time (cold) population on an event port. The guest OS reads the bitmaps through fixed 32-bit I/O registers. It acknowledges a removal by writing a slot mask to the eject register. Every hot insertion or removal raises a shared general-purpose-event status flag. A power-management block elsewhere merges that flag into its interrupt.

A platform reset request starts an internal sequencer. The sequencer retires every pending removal, one slot per clock, and then rebuilds the removable map and the present map from the platform's slot inputs. The `busy` output stays high while it works. Events and eject writes that arrive in that window are dropped.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: After the asynchronous reset, the present and pending-removal maps read zero, the removable map reads 0xFFFFFFFF, the event status and enable fields read zero, and `busy` is low.
- R2: An insert event (`evt_kind` = 1) sets the slot's present bit and the event status flag.
- R3: A remove event (`evt_kind` = 2) sets the slot's bit in the pending-removal map (read at 0xAE04) and the event status flag. It leaves the present map unchanged.
- R4: A cold event (`evt_kind` = 0) sets only the slot's present bit and does not raise the event status flag.
- R5: A read of 0xAE00 returns present AND removable. A read of 0xAE04 returns the pending-removal map, a read of 0xAE0C returns the removable map, and a read of 0xAE08 returns 0.
- R6: A write to 0xAE08 picks the lowest set bit of the data as the slot and clears that slot's pending-removal bit. It clears the slot's present bit when `slot_fixed` for that slot is low. Other set bits in the data are ignored.
- R7: When `slot_fixed` is high for the ejected slot, the eject leaves its present bit set.
- R8: An eject write of zero changes no map.
- R9: The 32-bit register at 0xAFE0 holds the status flag in bit 1, which is write-one-to-clear, and a 16-bit enable field in bits 31:16, which reads back what was written. If a clearing write and a hot event fall in the same cycle, the flag stays set.
- R10: A `rebuild_req` pulse holds `busy` high for one cycle per pending removal plus one cycle. When `busy` falls, the pending-removal map is zero, the removable map equals the inverse of `slot_fixed`, and the present map equals `slot_populated`.
- R11: While `busy` is high, events and eject writes have no effect, so an insert event in that window does not raise the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Slot event strobe |
| evt_kind | input | 2 | 0 cold, 1 insert, 2 remove, 3 none |
| evt_slot | input | 5 | Slot number of the event |
| slot_fixed | input | 32 | Per slot: device cannot be removed |
| slot_populated | input | 32 | Per slot: device fitted, used on rebuild |
| rebuild_req | input | 1 | Platform reset request, starts drain and rebuild |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, combinational |
| gpe_hp_sts | output | 1 | Hotplug event status flag |
| busy | output | 1 | Drain and rebuild in progress |

## Verification
A guest write that clears the status flag can land in the same clock as a new hot insertion, and these two must not cancel each other. The bench drives the clearing write to 0xAFE0 and an insert event on the same negative edge, then reads the register after the next rising edge. The flag must still be set, and the present map must show the new slot. A second case pairs an insert event with the first busy cycle of a rebuild, and the flag must stay clear.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    EV_COLD   = 2'd0,
    EV_INSERT = 2'd1,
    EV_REMOVE = 2'd2,
    EV_NONE   = 2'd3
  } hp_evt_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } hp_state_e;
endpackage

// File: rtl/hp_gpe.sv
module hp_gpe #(
  parameter int EN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic            wr_i,
  input  logic            clr_bit_i,
  input  logic [EN_W-1:0] en_wdata_i,
  output logic            sts_o,
  output logic [EN_W-1:0] en_o
);
  logic sts_q, sts_d;
  logic [EN_W-1:0] en_q;

  always_comb begin
    sts_d = sts_q;
    if (wr_i && clr_bit_i) sts_d = 1'b0;
    if (set_i) sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      if (wr_i) en_q <= en_wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;

  AST_GPE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> sts_q); // R9
  AST_GPE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && clr_bit_i && !set_i) |=> !sts_q); // R9
endmodule

// File: rtl/hp_slot_maps.sv
module hp_slot_maps
  import hp_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  hp_evt_e          evt_kind,
  input  logic [SW-1:0]    evt_slot,
  input  logic             ej_req,
  input  logic [SLOTS-1:0] ej_data,
  input  logic [SLOTS-1:0] slot_fixed,
  input  logic [SLOTS-1:0] slot_populated,
  input  logic             rebuild_req,
  output logic [SLOTS-1:0] present_o,
  output logic [SLOTS-1:0] removable_o,
  output logic [SLOTS-1:0] down_o,
  output logic             hot_evt_o,
  output logic             busy_o
);
  function automatic logic [SW-1:0] lowest_set(input logic [SLOTS-1:0] v);
    logic [SW-1:0] idx;
    idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i]) idx = SW'(i);
    end
    return idx;
  endfunction

  hp_state_e state_q, state_d;
  logic [SLOTS-1:0] present_q, present_d;
  logic [SLOTS-1:0] removable_q, removable_d;
  logic [SLOTS-1:0] down_q, down_d;
  logic busy, evt_ok, ej_ok, maps_en;
  logic [SW-1:0] ej_slot, drain_slot;

  assign busy       = (state_q == ST_DRAIN);
  assign evt_ok     = evt_valid && !busy && (evt_kind != EV_NONE) &&
                      (int'(evt_slot) < SLOTS);
  assign ej_ok      = ej_req && !busy && (|ej_data);
  assign ej_slot    = lowest_set(ej_data);
  assign drain_slot = lowest_set(down_q);
  assign maps_en    = evt_ok || ej_ok || busy || rebuild_req;

  always_comb begin
    state_d     = state_q;
    present_d   = present_q;
    removable_d = removable_q;
    down_d      = down_q;
    case (state_q)
      ST_IDLE: begin
        if (ej_ok) begin
          down_d[ej_slot] = 1'b0;
          if (!slot_fixed[ej_slot]) present_d[ej_slot] = 1'b0;
        end
        if (evt_ok) begin
          if (evt_kind == EV_REMOVE) down_d[evt_slot] = 1'b1;
          else                       present_d[evt_slot] = 1'b1;
        end
        if (rebuild_req) state_d = ST_DRAIN;
      end
      default: begin
        if (|down_q) begin
          down_d[drain_slot] = 1'b0;
          if (!slot_fixed[drain_slot]) present_d[drain_slot] = 1'b0;
        end else begin
          removable_d = ~slot_fixed;
          present_d   = slot_populated;
          state_d     = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      present_q   <= '0;
      removable_q <= '1;
      down_q      <= '0;
    end else if (maps_en) begin
      state_q     <= state_d;
      present_q   <= present_d;
      removable_q <= removable_d;
      down_q      <= down_d;
    end
  end

  assign present_o   = present_q;
  assign removable_o = removable_q;
  assign down_o      = down_q;
  assign busy_o      = busy;
  assign hot_evt_o   = evt_ok && (evt_kind != EV_COLD);

  AST_EJECT_CLEARS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_ok && !(evt_ok && evt_kind == EV_REMOVE)) |=> !down_q[$past(ej_slot)]); // R6
  AST_FIXED_KEEPS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_ok && slot_fixed[ej_slot] && present_q[ej_slot]) |=> present_q[$past(ej_slot)]); // R7
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (down_q == '0)); // R10
  AST_ZERO_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_req && ej_data == '0 && !evt_valid && !busy && !rebuild_req) |=> $stable(down_q) && $stable(present_q)); // R8
endmodule

// File: rtl/hp_io_regs.sv
module hp_io_regs #(
  parameter int          SLOTS    = 32,
  parameter int          EN_W     = 16,
  parameter logic [15:0] A_UP     = 16'hAE00,
  parameter logic [15:0] A_DOWN   = 16'hAE04,
  parameter logic [15:0] A_EJECT  = 16'hAE08,
  parameter logic [15:0] A_REMOV  = 16'hAE0C,
  parameter logic [15:0] A_GPE    = 16'hAFE0
) (
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [15:0]      io_addr,
  input  logic [SLOTS-1:0] present_i,
  input  logic [SLOTS-1:0] removable_i,
  input  logic [SLOTS-1:0] down_i,
  input  logic             gpe_sts_i,
  input  logic [EN_W-1:0]  gpe_en_i,
  output logic             ej_req_o,
  output logic             gpe_wr_o,
  output logic [31:0]      io_rdata
);
  assign ej_req_o = io_wr && (io_addr == A_EJECT);
  assign gpe_wr_o = io_wr && (io_addr == A_GPE);

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      case (io_addr)
        A_UP:    io_rdata = 32'(present_i & removable_i);
        A_DOWN:  io_rdata = 32'(down_i);
        A_REMOV: io_rdata = 32'(removable_i);
        A_GPE:   io_rdata = {gpe_en_i, 14'd0, gpe_sts_i, 1'b0};
        default: io_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
  import hp_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int EN_W  = 16,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  input  logic [SW-1:0]    evt_slot,
  input  logic [SLOTS-1:0] slot_fixed,
  input  logic [SLOTS-1:0] slot_populated,
  input  logic             rebuild_req,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [15:0]      io_addr,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             gpe_hp_sts,
  output logic             busy
);
  logic [SLOTS-1:0] present, removable, down;
  logic [EN_W-1:0]  gpe_en;
  logic ej_req, gpe_wr, hot_evt;

  hp_slot_maps #(.SLOTS(SLOTS)) u_maps (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_kind(hp_evt_e'(evt_kind)), .evt_slot(evt_slot),
    .ej_req(ej_req), .ej_data(io_wdata[SLOTS-1:0]),
    .slot_fixed(slot_fixed), .slot_populated(slot_populated),
    .rebuild_req(rebuild_req),
    .present_o(present), .removable_o(removable), .down_o(down),
    .hot_evt_o(hot_evt), .busy_o(busy)
  );

  hp_gpe #(.EN_W(EN_W)) u_gpe (
    .clk(clk), .rst_n(rst_n),
    .set_i(hot_evt), .wr_i(gpe_wr), .clr_bit_i(io_wdata[1]),
    .en_wdata_i(io_wdata[31:32-EN_W]),
    .sts_o(gpe_hp_sts), .en_o(gpe_en)
  );

  hp_io_regs #(.SLOTS(SLOTS), .EN_W(EN_W)) u_regs (
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .present_i(present), .removable_i(removable), .down_i(down),
    .gpe_sts_i(gpe_hp_sts), .gpe_en_i(gpe_en),
    .ej_req_o(ej_req), .gpe_wr_o(gpe_wr), .io_rdata(io_rdata)
  );

  AST_COLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'd0 && !gpe_hp_sts) |=> !gpe_hp_sts); // R4
  AST_BUSY_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !gpe_hp_sts) |=> !gpe_hp_sts); // R11
  AST_HOT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !busy && (evt_kind == 2'd1 || evt_kind == 2'd2)) |=> gpe_hp_sts); // R2
endmodule

// File: tb/slot_hotplug_ctrl_tb.sv
`timescale 1ns/1ps
module slot_hotplug_ctrl_tb;
  localparam logic [15:0] A_UP = 16'hAE00, A_DOWN = 16'hAE04, A_EJ = 16'hAE08,
                          A_RM = 16'hAE0C, A_GPE = 16'hAFE0;

  logic clk = 1'b0;
  logic rst_n;
  logic evt_valid, rebuild_req, io_wr, io_rd, gpe_hp_sts, busy;
  logic [1:0] evt_kind;
  logic [4:0] evt_slot;
  logic [31:0] slot_fixed, slot_populated, io_wdata, io_rdata;
  logic [15:0] io_addr;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slot_hotplug_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_slot(evt_slot), .slot_fixed(slot_fixed), .slot_populated(slot_populated),
    .rebuild_req(rebuild_req), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .gpe_hp_sts(gpe_hp_sts), .busy(busy)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    io_rd = 1'b1; io_addr = a; #1; v = io_rdata; io_rd = 1'b0;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d; tick(); io_wr = 1'b0; io_wdata = '0;
  endtask

  task automatic ev(logic [1:0] k, logic [4:0] s);
    evt_valid = 1'b1; evt_kind = k; evt_slot = s; tick(); evt_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_UP, v);  check("R1 up", v, 32'h0);
    rd(A_DOWN, v); check("R1 down", v, 32'h0);
    rd(A_RM, v);  check("R1 removable", v, 32'hFFFFFFFF);
    rd(A_GPE, v); check("R1 gpe", v, 32'h0);
    check("R1 busy", {31'd0, busy}, 32'h0);
    rd(A_EJ, v);  check("R5 eject feature read", v, 32'h0);
  endtask

  task automatic t_insert();
    logic [31:0] v;
    ev(2'd1, 5'd3);
    rd(A_UP, v);  check("R2 insert present", v, 32'h8);
    rd(A_GPE, v); check("R2 insert gpe", v, 32'h2);
  endtask

  task automatic t_gpe_regs();
    logic [31:0] v;
    wr(A_GPE, 32'hABCD_0002);
    rd(A_GPE, v); check("R9 w1c and enable", v, 32'hABCD_0000);
  endtask

  task automatic t_remove();
    logic [31:0] v;
    ev(2'd2, 5'd3);
    rd(A_DOWN, v); check("R3 down set", v, 32'h8);
    rd(A_UP, v);   check("R3 present kept", v, 32'h8);
    rd(A_GPE, v);  check("R3 gpe", v[1:0], 32'h2);
  endtask

  task automatic t_cold();
    logic [31:0] v;
    wr(A_GPE, 32'h2);
    ev(2'd0, 5'd7);
    rd(A_UP, v);  check("R4 cold present", v, 32'h88);
    rd(A_GPE, v); check("R4 cold no gpe", v[1:0], 32'h0);
  endtask

  task automatic t_eject();
    logic [31:0] v;
    ev(2'd2, 5'd7);
    rd(A_DOWN, v); check("R5 down map", v, 32'h88);
    wr(A_EJ, 32'h88);
    rd(A_DOWN, v); check("R6 lowest only down", v, 32'h80);
    rd(A_UP, v);   check("R6 lowest only present", v, 32'h80);
  endtask

  task automatic t_fixed();
    logic [31:0] v;
    slot_fixed = 32'h80;
    wr(A_EJ, 32'h80);
    rd(A_DOWN, v); check("R7 down cleared", v, 32'h0);
    rd(A_UP, v);   check("R7 fixed present kept", v, 32'h80);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    ev(2'd2, 5'd9);
    wr(A_EJ, 32'h0);
    rd(A_DOWN, v); check("R8 zero eject down", v, 32'h200);
    rd(A_UP, v);   check("R8 zero eject up", v, 32'h80);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    io_wr = 1'b1; io_addr = A_GPE; io_wdata = 32'h2;
    evt_valid = 1'b1; evt_kind = 2'd1; evt_slot = 5'd12;
    tick();
    io_wr = 1'b0; io_wdata = '0; evt_valid = 1'b0;
    rd(A_GPE, v); check("R9 set beats clear", v[1:0], 32'h2);
    rd(A_UP, v);  check("R9 same-cycle insert", v, 32'h1080);
  endtask

  task automatic t_rebuild();
    logic [31:0] v;
    int n;
    ev(2'd2, 5'd1);
    ev(2'd2, 5'd5);
    wr(A_GPE, 32'h2);
    rd(A_DOWN, v); check("R10 pre down", v, 32'h222);
    slot_populated = 32'h0000_F0F0;
    rebuild_req = 1'b1; tick(); rebuild_req = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (n == 1) begin evt_valid = 1'b1; evt_kind = 2'd1; evt_slot = 5'd20; end
      else evt_valid = 1'b0;
      tick();
    end
    evt_valid = 1'b0;
    check("R10 busy cycles", n, 32'd4);
    rd(A_GPE, v);  check("R11 event ignored while busy", v[1:0], 32'h0);
    rd(A_DOWN, v); check("R10 down empty", v, 32'h0);
    rd(A_RM, v);   check("R10 removable rebuilt", v, 32'hFFFF_FF7F);
    rd(A_UP, v);   check("R10 up rebuilt", v, 32'h0000_F070);
  endtask

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_kind = 2'd3; evt_slot = '0;
    slot_fixed = '0; slot_populated = '0; rebuild_req = 1'b0;
    io_wr = 1'b0; io_rd = 1'b0; io_addr = '0; io_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_insert();
    t_gpe_regs();
    t_remove();
    t_cold();
    t_eject();
    t_fixed();
    t_zero();
    t_same_cycle();
    t_rebuild();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule